// File: doc/BRIEF.md
# Key-Selected Rate LED Counter

This block runs a 4-bit up-counter whose four bits drive LEDs. The counter advances at one of five rates. A free-running binary prescaler clocked by the 50 MHz system clock sets each rate, and its divisor is a power of two: 2^3, 2^23, 2^24, 2^25 or 2^26. The 2^3 setting is there only so that simulation runs are short. The other four settings are slow enough to follow by eye.

A serial receiver outside this block delivers each received byte with a valid strobe that lasts one clock. The keys '1' to '5' pick the rate. Any other byte is dropped and the current rate is kept.

The prescaler runs without stopping. It produces a tick that lasts one clock whenever its low bits for the selected tap are all ones. The counter adds one on each tick, so the whole block stays in a single clock domain. An asynchronous active-high reset, wired to a slide switch, clears the counter and the prescaler and selects the slowest rate.

Top module: `rate_led_counter`

## Requirements
- R1: While reset is high, and after it is released, `led_count` is 0 and `rate_sel` is 4, which is the slowest rate.
- R2: A strobed byte 0x31, 0x32, 0x33, 0x34 or 0x35 sets `rate_sel` to 0, 1, 2, 3 or 4, in that order. The new value appears at the clock edge that samples the strobe.
- R3: A strobed byte outside 0x31 to 0x35 leaves `rate_sel` unchanged.
- R4: With rate_sel = k, the counter adds one every 2^TAP(k) clocks. The default taps are 3, 23, 24, 25 and 26. With N edges since reset, the increment falls on every edge where N is a multiple of 2^TAP(k).
- R5: The counter wraps from 15 to 0.
- R6: A byte presented while `cmd_valid` is low has no effect on `rate_sel`.
- R7: Changing the rate does not restart the prescaler. After the change, ticks fall on the edges where the running edge count is a multiple of the new divisor.
- R8: Reset acts asynchronously. Raising it between clock edges clears `led_count` and returns `rate_sel` to 4 before the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, 50 MHz nominal |
| rst | input | 1 | Asynchronous active-high reset from a slide switch |
| cmd_byte | input | 8 | Byte from the serial receiver |
| cmd_valid | input | 1 | One-clock strobe qualifying cmd_byte |
| led_count | output | 4 | Counter value driving the LEDs |
| rate_sel | output | 3 | Current rate index, 0 (fastest) to 4 (slowest) |

## Verification
The bench uses short taps of 3 to 7 bits. It compares every cycle against an arithmetic model built on the edge count, so a tap off by one, or a prescaler cleared on a rate change, shows up as a counter that steps on the wrong edge. It sweeps all 256 byte values. A decoder with an off-by-one range, such as accepting '0' or '6', would move the selection. A run at the fastest rate passes through 15, so a counter that saturates or skips the wrap fails. A reset pulse between edges catches a design that only clears on the clock.

// File: rtl/rate_pkg.sv
package rate_pkg;
  localparam int TAP_FIELD_W = 8;
  localparam logic [7:0] KEY_FIRST = 8'h31;

  function automatic int tap_at(input logic [63:0] taps, input int idx);
    return int'(taps[idx*TAP_FIELD_W +: TAP_FIELD_W]);
  endfunction
endpackage

// File: rtl/rate_cmd_decode.sv
module rate_cmd_decode #(
  parameter int NUM_RATES = 5,
  parameter logic [7:0] KEY_BASE = rate_pkg::KEY_FIRST,
  localparam int SEL_W = $clog2(NUM_RATES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [7:0]       cmd_byte,
  input  logic             cmd_valid,
  output logic [SEL_W-1:0] sel_q
);
  logic [7:0] idx;
  logic       hit;

  assign idx = cmd_byte - KEY_BASE;
  assign hit = cmd_valid && (idx < 8'(NUM_RATES));

  always_ff @(posedge clk or posedge rst) begin
    if (rst) sel_q <= SEL_W'(NUM_RATES - 1);
    else if (hit) sel_q <= idx[SEL_W-1:0];
  end

  AST_SEL_LEGAL: assert property (@(posedge clk) disable iff (rst)
    sel_q < SEL_W'(NUM_RATES)); // R2
  AST_KEY_LOADS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_byte >= KEY_BASE && cmd_byte < KEY_BASE + 8'(NUM_RATES))
      |=> (8'(sel_q) == $past(cmd_byte) - KEY_BASE)); // R2
  AST_BAD_KEY_KEEPS: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && (cmd_byte < KEY_BASE || cmd_byte >= KEY_BASE + 8'(NUM_RATES)))
      |=> $stable(sel_q)); // R3
  AST_NO_STROBE_KEEPS: assert property (@(posedge clk) disable iff (rst)
    !cmd_valid |=> $stable(sel_q)); // R6
endmodule

// File: rtl/rate_prescaler.sv
module rate_prescaler #(
  parameter int NUM_RATES = 5,
  parameter logic [63:0] TAPS = {24'd0, 8'd26, 8'd25, 8'd24, 8'd23, 8'd3},
  parameter int PRE_W = 26,
  localparam int SEL_W = $clog2(NUM_RATES)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  logic [PRE_W-1:0]     pre_q;
  logic [NUM_RATES-1:0] tap_hit;

  always_ff @(posedge clk or posedge rst) begin
    if (rst) pre_q <= '0;
    else pre_q <= pre_q + 1'b1;
  end

  for (genvar i = 0; i < NUM_RATES; i++) begin : g_tap
    localparam int T = rate_pkg::tap_at(TAPS, i);
    assign tap_hit[i] = &pre_q[T-1:0];
  end

  assign tick = tap_hit[sel];

  AST_PRE_FREE_RUN: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (pre_q == $past(pre_q) + 1'b1)); // R7
endmodule

// File: rtl/led_step_counter.sv
module led_step_counter #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             step,
  output logic [CNT_W-1:0] count_q
);
  always_ff @(posedge clk or posedge rst) begin
    if (rst) count_q <= '0;
    else if (step) count_q <= count_q + 1'b1;
  end

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(count_q)); // R4
  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    step |=> (count_q == CNT_W'($past(count_q) + 1'b1))); // R4
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (rst)
    (step && count_q == '1) |=> (count_q == '0)); // R5
endmodule

// File: rtl/rate_led_counter.sv
module rate_led_counter #(
  parameter int NUM_RATES = 5,
  parameter int CNT_W = 4,
  parameter logic [7:0] KEY_BASE = rate_pkg::KEY_FIRST,
  parameter logic [63:0] TAPS = {24'd0, 8'd26, 8'd25, 8'd24, 8'd23, 8'd3}
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] cmd_byte,
  input  logic       cmd_valid,
  output logic [3:0] led_count,
  output logic [2:0] rate_sel
);
  function automatic int widest_tap(input logic [63:0] t);
    int m = 1;
    for (int i = 0; i < NUM_RATES; i++)
      if (rate_pkg::tap_at(t, i) > m) m = rate_pkg::tap_at(t, i);
    return m;
  endfunction

  localparam int PRE_W = widest_tap(TAPS);
  localparam int SEL_W = $clog2(NUM_RATES);

  logic [SEL_W-1:0] sel;
  logic             tick;
  logic [CNT_W-1:0] cnt;

  rate_cmd_decode #(.NUM_RATES(NUM_RATES), .KEY_BASE(KEY_BASE)) u_decode (
    .clk(clk), .rst(rst), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid), .sel_q(sel));

  rate_prescaler #(.NUM_RATES(NUM_RATES), .TAPS(TAPS), .PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .sel(sel), .tick(tick));

  led_step_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .step(tick), .count_q(cnt));

  assign led_count = 4'(cnt);
  assign rate_sel  = 3'(sel);

  AST_RESET_VALUES: assert property (@(posedge clk)
    $fell(rst) |-> (led_count == 4'd0 && rate_sel == 3'(NUM_RATES - 1))); // R1
endmodule

// File: tb/rate_led_counter_bench.sv
module rate_led_counter_bench;
  localparam logic [63:0] TB_TAPS = {24'd0, 8'd7, 8'd6, 8'd5, 8'd4, 8'd3};
  localparam int TB_TAP [5] = '{3, 4, 5, 6, 7};

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] cmd_byte = 8'h00;
  logic       cmd_valid = 1'b0;
  logic [3:0] led_count;
  logic [2:0] rate_sel;

  int checks = 0;
  int fails = 0;
  int edges = 0;
  int m_sel = 4;
  int m_cnt = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  rate_led_counter #(.TAPS(TB_TAPS)) u_rate_led_counter (
    .clk(clk), .rst(rst), .cmd_byte(cmd_byte), .cmd_valid(cmd_valid),
    .led_count(led_count), .rate_sel(rate_sel));

  // Arithmetic model: tick on edge N when N is a multiple of 2^tap(selection before edge).
  always @(posedge clk or posedge rst) begin
    if (rst) begin
      edges = 0; m_sel = 4; m_cnt = 0;
    end else begin
      int old_sel;
      old_sel = m_sel;
      edges = edges + 1;
      if (cmd_valid && cmd_byte >= 8'h31 && cmd_byte <= 8'h35) m_sel = int'(cmd_byte) - 'h31;
      if ((edges % (1 << TB_TAP[old_sel])) == 0) m_cnt = (m_cnt + 1) % 16;
    end
  end

  task automatic check(input string req);
    checks++;
    if (led_count !== 4'(m_cnt) || rate_sel !== 3'(m_sel)) begin
      fails++;
      $display("FAIL %s: count=%0d sel=%0d expected count=%0d sel=%0d",
               req, led_count, rate_sel, m_cnt, m_sel);
    end
  endtask

  task automatic run(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1;
      check(req);
    end
  endtask

  task automatic send(input logic [7:0] b, input logic v, input string req);
    cmd_byte = b; cmd_valid = v;
    @(posedge clk); #1;
    cmd_valid = 1'b0;
    check(req);
  endtask

  initial begin
    #400000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1; check("R1 during reset");
    rst = 1'b0;
    run(2, "R1 after release");
    run(300, "R4 slowest rate");
    send(8'h31, 1'b1, "R2 key 1");
    run(200, "R5 wrap at fastest rate");
    send(8'h32, 1'b1, "R2 key 2");
    run(260, "R7 rate 1");
    send(8'h33, 1'b1, "R2 key 3");
    run(260, "R7 rate 2");
    send(8'h34, 1'b1, "R2 key 4");
    run(260, "R7 rate 3");
    send(8'h35, 1'b1, "R2 key 5");
    run(140, "R4 rate 4");
    send(8'h31, 1'b1, "R2 back to key 1");
    for (int b = 0; b < 256; b++) begin
      if (b < 'h31 || b > 'h35) send(8'(b), 1'b1, "R3 ignored byte");
      else send(8'(b), 1'b0, "R6 unstrobed key");
      run(1, "R3 hold");
    end
    run(40, "R4 after sweep");
    #1 rst = 1'b1;
    #0.5;
    check("R8 async clear");
    @(negedge clk); rst = 1'b0;
    run(50, "R1 restart");
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule